// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block receives the serial frames a PS/2 keyboard sends on its clock and data lines and presents each good scan-code byte on a parallel bus with a valid flag. Both incoming lines are first brought into the system clock domain through a synchronizer chain and then debounced: a line's filtered value changes only after the synchronized input has held its new level for a set number of system clocks. Each bit is shifted into an 11-bit register on a falling edge of the filtered PS/2 clock.

The receiver does not count bits. A frame is complete once the filtered PS/2 clock has stayed high for a programmable number of system clocks, chosen to cover half of the slowest keyboard clock period. For example, 50 us is 2500 cycles at 50 MHz. At that point combinational logic checks the start bit, the stop bit and odd parity. If all three pass, the byte is registered onto the output bus and the valid flag rises. The flag stays high and the byte stays on the bus until the next frame begins, which shows up as a low filtered PS/2 clock. The block only listens. It never drives the lines and does not interpret multi-byte make or break sequences.

Top module: `ps2_frame_rx`

## Requirements
- R1: After synchronous reset, `code_o` is 0x00 and `code_valid_o` is 0.
- R2: A frame consists of a low start bit, 8 data bits with the least significant bit first, a parity bit and a high stop bit. Each bit is taken on a falling edge of the filtered PS/2 clock. After a good frame, `code_o` equals the 8 data bits and `code_valid_o` is 1.
- R3: Parity is odd: the 8 data bits plus the parity bit must hold an odd number of ones. A frame that breaks this leaves `code_o` unchanged and `code_valid_o` at 0.
- R4: A frame whose start bit is 1, or whose stop bit is 0, is discarded in the same way.
- R5: A frame is judged only after the filtered PS/2 clock has been high for `IDLE_CYCLES` consecutive system clocks. `code_valid_o` does not rise before then.
- R6: `code_valid_o` and `code_o` hold their values until the filtered PS/2 clock next goes low. `code_valid_o` then falls within one system clock of that low.
- R7: A pulse on either line that is shorter than `STABLE_CYCLES` system clocks is ignored. It neither shifts a bit nor clears the valid flag.
- R8: A frame with too few bits is discarded, because the shift register is refilled with ones after every completion check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Raw PS/2 clock line from the keyboard |
| ps2_data_i | input | 1 | Raw PS/2 data line from the keyboard |
| code_o | output | 8 | Last accepted scan-code byte |
| code_valid_o | output | 1 | High while `code_o` holds a byte and no new frame has started |

## Verification
The bound assertions check on every cycle that the valid flag rises only on a completion event, only while the filtered clock is high, and only after a frame that passed all checks. They also check that the flag falls right after a low filtered clock and that the byte on the bus is steady while the flag is high. Only the bench scenarios can show that the bit order and parity rule produce the correct byte for every data value, and that malformed, truncated or glitched input is rejected. The bench alone also shows the timing of completion relative to the last clock edge.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;
  localparam int LINES   = 2;
  localparam int LINE_CLK  = 0;
  localparam int LINE_DATA = 1;
  typedef logic [DATA_W-1:0]  byte_t;
  typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          hold_cnt;
  logic                   sampled;

  assign sampled = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      line_o   <= 1'b1;
    end else if (sampled == line_o) begin
      hold_cnt <= '0;
    end else if (hold_cnt == CW'(STABLE_CYCLES - 1)) begin
      hold_cnt <= '0;
      line_o   <= sampled;
    end else begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ps2_idle_timer.sv
module ps2_idle_timer #(
  parameter int IDLE_CYCLES = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic line_hi,
  output logic expire_o
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);

  logic [CW-1:0] high_cnt;

  always_ff @(posedge clk) begin
    if (rst || !line_hi)                   high_cnt <= '0;
    else if (high_cnt != CW'(IDLE_CYCLES)) high_cnt <= high_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) expire_o <= 1'b0;
    else     expire_o <= line_hi && (high_cnt == CW'(IDLE_CYCLES - 1));
  end
endmodule

// File: rtl/ps2_frame_check.sv
module ps2_frame_check
  import ps2_rx_pkg::*;
(
  input  frame_t frame_i,
  output logic   good_o
);
  logic start_ok, stop_ok, parity_ok;

  assign start_ok  = (frame_i[0] == 1'b0);
  assign stop_ok   = (frame_i[FRAME_W-1] == 1'b1);
  assign parity_ok = ^frame_i[FRAME_W-2:1];
  assign good_o    = start_ok && stop_ok && parity_ok;
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int STABLE_CYCLES = 8,
  parameter int IDLE_CYCLES   = 2500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic [7:0] code_o,
  output logic       code_valid_o
);
  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] filt_lines;
  logic             clk_filt, data_filt, clk_filt_q, clk_fall;
  logic             idle_expire, frame_good;
  frame_t           shreg;

  assign raw_lines[LINE_CLK]  = ps2_clk_i;
  assign raw_lines[LINE_DATA] = ps2_data_i;

  for (genvar g = 0; g < LINES; g++) begin : g_filter
    ps2_line_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_CYCLES(STABLE_CYCLES)
    ) u_filt (
      .clk   (clk),
      .rst   (rst),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign clk_filt  = filt_lines[LINE_CLK];
  assign data_filt = filt_lines[LINE_DATA];

  always_ff @(posedge clk) begin
    if (rst) clk_filt_q <= 1'b1;
    else     clk_filt_q <= clk_filt;
  end
  assign clk_fall = clk_filt_q && !clk_filt;

  ps2_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .line_hi (clk_filt),
    .expire_o(idle_expire)
  );

  ps2_frame_check u_check (
    .frame_i(shreg),
    .good_o (frame_good)
  );

  always_ff @(posedge clk) begin
    if (rst)              shreg <= '1;
    else if (idle_expire) shreg <= '1;
    else if (clk_fall)    shreg <= {data_filt, shreg[FRAME_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_o       <= '0;
      code_valid_o <= 1'b0;
    end else if (!clk_filt) begin
      code_valid_o <= 1'b0;
    end else if (idle_expire && frame_good) begin
      code_o       <= shreg[DATA_W:1];
      code_valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ps2_frame_rx_chk.sv
module ps2_frame_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       clk_filt,
  input logic       idle_expire,
  input logic       frame_good,
  input logic [7:0] code_o,
  input logic       code_valid_o
);
  AST_RISE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(code_valid_o) |-> $past(idle_expire)); // R5
  AST_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(code_valid_o) |-> clk_filt); // R5
  AST_RISE_GOOD_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(code_valid_o) |-> $past(frame_good)); // R3
  AST_CLEAR_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    !clk_filt |=> !code_valid_o); // R6
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    code_valid_o |=> (!code_valid_o || $stable(code_o))); // R6
  AST_EXPIRE_HIGH: assert property (@(posedge clk) disable iff (rst)
    idle_expire |-> clk_filt); // R5
endmodule

bind ps2_frame_rx ps2_frame_rx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .clk_filt    (clk_filt),
  .idle_expire (idle_expire),
  .frame_good  (frame_good),
  .code_o      (code_o),
  .code_valid_o(code_valid_o)
);

// File: tb/ps2_frame_rx_tb.sv
module ps2_frame_rx_tb_top;
  localparam int IDLE = 36;
  localparam int STAB = 4;
  localparam int HALF = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kclk = 1'b1;
  logic       kdat = 1'b1;
  logic [7:0] code;
  logic       valid;
  int         checks = 0;
  int         failures = 0;
  logic [7:0] last_code = 8'h00;

  always #10 clk = ~clk;

  ps2_frame_rx #(.SYNC_STAGES(2), .STABLE_CYCLES(STAB), .IDLE_CYCLES(IDLE)) dut_i (
    .clk(clk), .rst(rst), .ps2_clk_i(kclk), .ps2_data_i(kdat),
    .code_o(code), .code_valid_o(valid)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [10:0] bits, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      kdat = bits[b];
      wait_cyc(HALF);
      kclk = 1'b0;
      wait_cyc(HALF);
      if (b == 0) chk("R6 clear", {8'h0, valid}, 9'h0);
      kclk = 1'b1;
    end
    kdat = 1'b1;
  endtask

  function automatic logic [10:0] mk(input logic [7:0] d, input logic st,
                                     input logic flip, input logic sp);
    return {sp, ~(^d) ^ flip, d, st};
  endfunction

  task automatic expect_good(input logic [7:0] d);
    wait_cyc(IDLE / 2);
    chk("R5 early", {8'h0, valid}, 9'h0);
    wait_cyc(IDLE + 20);
    chk("R2 byte", {code, valid}, {d, 1'b1});
    last_code = d;
  endtask

  task automatic expect_drop();
    wait_cyc(2 * IDLE + 20);
    chk("R3/R4/R8 drop", {code, valid}, {last_code, 1'b0});
  endtask

  initial begin
    wait_cyc(200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    chk("R1 reset", {code, valid}, 9'h0);
    wait_cyc(IDLE + 20);
    chk("R1 idle", {code, valid}, 9'h0);
    // R2 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      send_bits(mk(8'(v), 1'b0, 1'b0, 1'b1), 11);
      expect_good(8'(v));
      if (v % 32 == 5) begin
        wait_cyc(50);
        chk("R6 hold", {code, valid}, {8'(v), 1'b1});
      end
    end
    // R7 glitches on clock and data while idle with valid high
    kclk = 1'b0; wait_cyc(STAB - 2); kclk = 1'b1;
    wait_cyc(20);
    chk("R7 clk glitch", {code, valid}, {last_code, 1'b1});
    kdat = 1'b0; wait_cyc(STAB - 2); kdat = 1'b1;
    wait_cyc(20);
    chk("R7 data glitch", {code, valid}, {last_code, 1'b1});
    // R3 parity errors
    for (int v = 0; v < 256; v += 37) begin
      send_bits(mk(8'(v), 1'b0, 1'b1, 1'b1), 11);
      expect_drop();
    end
    // R4 bad start and bad stop
    send_bits(mk(8'h5A, 1'b1, 1'b0, 1'b1), 11);
    expect_drop();
    send_bits(mk(8'hC3, 1'b0, 1'b0, 1'b0), 11);
    expect_drop();
    // R8 truncated frame
    send_bits(mk(8'h81, 1'b0, 1'b0, 1'b1), 10);
    expect_drop();
    // R7 clock glitch inside a frame adds no bit
    kdat = 1'b0; wait_cyc(HALF); kclk = 1'b0; wait_cyc(HALF); kclk = 1'b1;
    kdat = 1'b1; wait_cyc(4); kclk = 1'b0; wait_cyc(STAB - 2); kclk = 1'b1;
    send_bits(mk(8'h3C, 1'b0, 1'b0, 1'b1) >> 1, 10);
    expect_good(8'h3C);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule